// File: doc/BRIEF.md
# Quad Wiper and Preset Register Bank

This block holds the digital control state of four potentiometers. Each pot owns a 6-bit volatile wiper register and four 6-bit preset slots, which stand in for nonvolatile storage. A serial front end decodes host transactions and hands the bank one operation per strobe: read or write a wiper, read or write a preset, load a preset into a wiper, save a wiper into a preset, or step a wiper up or down. The bank drives a one-hot tap bus for each pot, which closes exactly one of the 64 switches along that pot's resistor string.

After reset the bank fills every wiper from preset slot 0. This recall runs as four internal load operations, one per pot, and busy is high while it runs. A save or a preset write starts a modeled nonvolatile write cycle. It lasts a fixed number of clocks and busy is high for its whole length. While a write cycle runs, further nonvolatile writes are refused, and all other operations still complete. An active-low protect pin blocks only the nonvolatile writes.

Top module: `potbank_ctrl`

## Requirements
- R1: `tap_sel[64p+63:64p]` is the tap bus of pot p. Bit k is high exactly when that pot's wiper holds k. Exactly one bit per pot is high in every cycle. A wiper change shows on the bus one cycle after the wiper register changes.
- R2: While `rst` is high, every wiper is 0 and bit 0 of each tap bus is high. After release, slot 0 of pots 0 to 3 is loaded into their wipers in that order. `busy` is high until the recall is done, and any operation offered during the recall is refused.
- R3: Opcode 1 writes `op_data` into the wiper of `op_pot`. Opcode 0 reads that wiper. A read result appears as a one-cycle `rd_valid` pulse with `rd_data`, on the second clock edge after the operation is sampled.
- R4: Opcode 3 writes `op_data` into preset `op_slot` of `op_pot`. Opcode 2 reads that preset back with the timing of R3.
- R5: Opcode 4 copies preset `op_slot` of `op_pot` into that pot's wiper.
- R6: Opcode 5 copies the wiper of `op_pot` into its preset `op_slot`.
- R7: Opcode 6 raises the wiper by one and holds it at 63. Opcode 7 lowers it by one and holds it at 0. Neither wraps.
- R8: With `wp_n` low, opcodes 3 and 5 are refused and the preset keeps its value. Wiper writes, loads and reads still take effect. A refusal is a one-cycle `op_refused` pulse on the first edge after the operation is sampled.
- R9: An accepted opcode 3 or 5 holds `busy` high for exactly WR_CYCLES cycles, starting on the second edge after the operation is sampled. `busy` is still low after the first edge.
- R10: While a write cycle is running, opcodes 3 and 5 are refused and leave the presets unchanged. Reads and wiper operations still complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; recall starts on release |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_code | input | 3 | Operation code (see R3 to R7) |
| op_pot | input | 2 | Target pot |
| op_slot | input | 2 | Target preset slot |
| op_data | input | 6 | Write data |
| wp_n | input | 1 | Active-low protect for preset writes and saves |
| op_refused | output | 1 | Pulse: the operation was rejected |
| rd_valid | output | 1 | Pulse: rd_data holds a read result |
| rd_data | output | 6 | Read result |
| busy | output | 1 | Recall or nonvolatile write cycle in progress |
| tap_sel | output | 256 | One-hot tap buses, 64 lines per pot |

## Verification
A vector table drives every opcode against different pots and slots. This separates a pot or slot addressing error from a data-path error. Step sequences start one tap away from each end and step past the end, which exposes wrap-around. The protect pin is driven low while presets, wipers and loads are mixed, which shows that only preset writes are blocked. Directed runs measure the busy window, offer writes and reads inside it, and repeat the reset after distinct slot-0 values have been written, so that a recall in the wrong order or from the wrong slot is caught.

// File: rtl/potbank_pkg.sv
package potbank_pkg;

  typedef enum logic [2:0] {
    OP_RD_WIPER  = 3'd0,
    OP_WR_WIPER  = 3'd1,
    OP_RD_PRESET = 3'd2,
    OP_WR_PRESET = 3'd3,
    OP_LOAD      = 3'd4,
    OP_SAVE      = 3'd5,
    OP_STEP_UP   = 3'd6,
    OP_STEP_DN   = 3'd7
  } pb_op_e;

  function automatic logic is_nv_write(input pb_op_e op);
    return (op == OP_WR_PRESET) || (op == OP_SAVE);
  endfunction

  function automatic logic is_read(input pb_op_e op);
    return (op == OP_RD_WIPER) || (op == OP_RD_PRESET);
  endfunction

endpackage

// File: rtl/pb_preset_mem.sv
module pb_preset_mem #(
  parameter int unsigned DW = 6,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Write-first read port: a write and a read to the same slot in one cycle
  // return the new data.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= (we && waddr == raddr) ? wdata : mem[raddr];
  end
endmodule

// File: rtl/pb_nv_timer.sv
module pb_nv_timer #(
  parameter int unsigned CYCLES = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start)       cnt <= CW'(CYCLES);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_TIMER_ARMS: assert property (@(posedge clk) disable iff (rst)
    start |=> busy); // R9
  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start); // R10
endmodule

// File: rtl/pb_tap_decode.sv
module pb_tap_decode #(
  parameter int unsigned WBITS = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [WBITS-1:0]        wiper,
  output logic [(1<<WBITS)-1:0]   taps
);
  localparam int unsigned NTAP = 1 << WBITS;

  always_ff @(posedge clk) begin
    if (rst) taps <= NTAP'(1);
    else     taps <= NTAP'(1) << wiper;
  end

  AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(taps) == 1); // R1
endmodule

// File: rtl/potbank_ctrl.sv
module potbank_ctrl
  import potbank_pkg::*;
#(
  parameter int unsigned NPOT      = 4,
  parameter int unsigned NSLOT     = 4,
  parameter int unsigned WBITS     = 6,
  parameter int unsigned WR_CYCLES = 50
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            op_valid,
  input  logic [2:0]                      op_code,
  input  logic [$clog2(NPOT)-1:0]         op_pot,
  input  logic [$clog2(NSLOT)-1:0]        op_slot,
  input  logic [WBITS-1:0]                op_data,
  input  logic                            wp_n,
  output logic                            op_refused,
  output logic                            rd_valid,
  output logic [WBITS-1:0]                rd_data,
  output logic                            busy,
  output logic [NPOT*(1<<WBITS)-1:0]      tap_sel
);
  localparam int unsigned PW   = $clog2(NPOT);
  localparam int unsigned SW   = $clog2(NSLOT);
  localparam int unsigned AW   = PW + SW;
  localparam int unsigned NTAP = 1 << WBITS;
  localparam logic [WBITS-1:0] WMAX = '1;

  pb_op_e op_in;
  assign op_in = pb_op_e'(op_code);

  // ---------------- recall sequencer ----------------
  logic          rcl_act;
  logic [PW-1:0] rcl_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rcl_act <= 1'b1;
      rcl_idx <= '0;
    end else if (rcl_act) begin
      rcl_idx <= rcl_idx + 1'b1;
      if (rcl_idx == PW'(NPOT - 1)) rcl_act <= 1'b0;
    end
  end

  // ---------------- stage 0: accept / refuse ----------------
  logic nv_busy, s1_nv, s1_vld, s1_rcl;
  logic nv_req, refuse, accept;

  assign nv_req = op_valid && is_nv_write(op_in);
  assign refuse = op_valid && (rcl_act || (nv_req && (!wp_n || nv_busy || s1_nv)));
  assign accept = op_valid && !refuse;

  logic             i_vld;
  pb_op_e           i_op;
  logic [PW-1:0]    i_pot;
  logic [SW-1:0]    i_slot;

  assign i_vld  = rcl_act || accept;
  assign i_op   = rcl_act ? OP_LOAD : op_in;
  assign i_pot  = rcl_act ? rcl_idx : op_pot;
  assign i_slot = rcl_act ? '0 : op_slot;

  // ---------------- stage 1 registers ----------------
  pb_op_e           s1_op;
  logic [PW-1:0]    s1_pot;
  logic [SW-1:0]    s1_slot;
  logic [WBITS-1:0] s1_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld     <= 1'b0;
      s1_rcl     <= 1'b0;
      s1_op      <= OP_RD_WIPER;
      s1_pot     <= '0;
      s1_slot    <= '0;
      s1_data    <= '0;
      op_refused <= 1'b0;
    end else begin
      s1_vld     <= i_vld;
      s1_rcl     <= rcl_act;
      s1_op      <= i_op;
      s1_pot     <= i_pot;
      s1_slot    <= i_slot;
      s1_data    <= op_data;
      op_refused <= refuse;
    end
  end

  assign s1_nv = s1_vld && is_nv_write(s1_op);

  // ---------------- wiper registers ----------------
  logic [WBITS-1:0] wiper [NPOT];
  logic [WBITS-1:0] mem_q;
  logic [WBITS-1:0] mem_wdata;

  assign mem_wdata = (s1_op == OP_SAVE) ? wiper[s1_pot] : s1_data;

  pb_preset_mem #(.DW(WBITS), .AW(AW)) mem_i (
    .clk   (clk),
    .we    (s1_nv),
    .waddr ({s1_pot, s1_slot}),
    .wdata (mem_wdata),
    .raddr ({i_pot, i_slot}),
    .rdata (mem_q)
  );

  pb_nv_timer #(.CYCLES(WR_CYCLES)) timer_i (
    .clk   (clk),
    .rst   (rst),
    .start (s1_nv),
    .busy  (nv_busy)
  );

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPOT; p++) begin
      if (rst) begin
        wiper[p] <= '0;
      end else if (s1_vld && s1_pot == PW'(p)) begin
        case (s1_op)
          OP_WR_WIPER: wiper[p] <= s1_data;
          OP_LOAD:     wiper[p] <= mem_q;
          OP_STEP_UP:  if (wiper[p] != WMAX) wiper[p] <= wiper[p] + 1'b1;
          OP_STEP_DN:  if (wiper[p] != '0)   wiper[p] <= wiper[p] - 1'b1;
          default:     ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= s1_vld && is_read(s1_op);
      if (s1_vld && is_read(s1_op))
        rd_data <= (s1_op == OP_RD_WIPER) ? wiper[s1_pot] : mem_q;
    end
  end

  assign busy = nv_busy || rcl_act || (s1_vld && s1_rcl);

  // ---------------- tap decoders ----------------
  for (genvar g = 0; g < NPOT; g++) begin : g_pot
    pb_tap_decode #(.WBITS(WBITS)) dec_i (
      .clk   (clk),
      .rst   (rst),
      .wiper (wiper[g]),
      .taps  (tap_sel[g*NTAP +: NTAP])
    );

    AST_STEP_UP_SAT: assert property (@(posedge clk) disable iff (rst)
      (s1_vld && s1_pot == PW'(g) && s1_op == OP_STEP_UP && wiper[g] == WMAX)
      |=> wiper[g] == WMAX); // R7
    AST_STEP_DN_SAT: assert property (@(posedge clk) disable iff (rst)
      (s1_vld && s1_pot == PW'(g) && s1_op == OP_STEP_DN && wiper[g] == '0)
      |=> wiper[g] == '0); // R7
  end

  AST_WP_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !wp_n && is_nv_write(op_in)) |=> op_refused); // R8
  AST_NV_REFUSE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (op_valid && nv_busy && is_nv_write(op_in)) |=> op_refused); // R10
  AST_READ_SERVED: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !rcl_act && is_read(op_in)) |=> !op_refused); // R10
  AST_RECALL_BUSY: assert property (@(posedge clk) disable iff (rst)
    rcl_act |-> busy); // R2
endmodule

// File: tb/potbank_ctrl_tb_top.sv
module potbank_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WRC = 50;

  localparam logic [2:0] RDW = 3'd0, WRW = 3'd1, RDP = 3'd2, WRP = 3'd3,
                         LDP = 3'd4, STP = 3'd5, UP  = 3'd6, DN  = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [1:0]  op_pot = '0;
  logic [1:0]  op_slot = '0;
  logic [5:0]  op_data = '0;
  logic        wp_n = 1'b1;
  logic        op_refused, rd_valid, busy;
  logic [5:0]  rd_data;
  logic [255:0] tap_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  potbank_ctrl #(.WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_pot(op_pot), .op_slot(op_slot), .op_data(op_data), .wp_n(wp_n),
    .op_refused(op_refused), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .tap_sel(tap_sel)
  );

  // {code, pot, slot, data, wp_n, exp_refused, exp_read}
  localparam int NV = 34;
  localparam logic [20:0] VEC [NV] = '{
    {WRP, 2'd0, 2'd0, 6'd10, 1'b1, 1'b0, 6'd0},
    {WRP, 2'd1, 2'd0, 6'd20, 1'b1, 1'b0, 6'd0},
    {WRP, 2'd2, 2'd0, 6'd30, 1'b1, 1'b0, 6'd0},
    {WRP, 2'd3, 2'd0, 6'd63, 1'b1, 1'b0, 6'd0},
    {WRP, 2'd0, 2'd2, 6'd45, 1'b1, 1'b0, 6'd0},
    {WRP, 2'd0, 2'd1, 6'd9,  1'b1, 1'b0, 6'd0},
    {RDP, 2'd0, 2'd2, 6'd0,  1'b1, 1'b0, 6'd45},
    {RDP, 2'd1, 2'd0, 6'd0,  1'b1, 1'b0, 6'd20},
    {WRW, 2'd1, 2'd0, 6'd5,  1'b1, 1'b0, 6'd0},
    {RDW, 2'd1, 2'd0, 6'd0,  1'b1, 1'b0, 6'd5},
    {LDP, 2'd1, 2'd0, 6'd0,  1'b1, 1'b0, 6'd0},
    {RDW, 2'd1, 2'd0, 6'd0,  1'b1, 1'b0, 6'd20},
    {WRW, 2'd2, 2'd0, 6'd62, 1'b1, 1'b0, 6'd0},
    {UP,  2'd2, 2'd0, 6'd0,  1'b1, 1'b0, 6'd0},
    {RDW, 2'd2, 2'd0, 6'd0,  1'b1, 1'b0, 6'd63},
    {UP,  2'd2, 2'd0, 6'd0,  1'b1, 1'b0, 6'd0},
    {RDW, 2'd2, 2'd0, 6'd0,  1'b1, 1'b0, 6'd63},
    {WRW, 2'd3, 2'd0, 6'd1,  1'b1, 1'b0, 6'd0},
    {DN,  2'd3, 2'd0, 6'd0,  1'b1, 1'b0, 6'd0},
    {RDW, 2'd3, 2'd0, 6'd0,  1'b1, 1'b0, 6'd0},
    {DN,  2'd3, 2'd0, 6'd0,  1'b1, 1'b0, 6'd0},
    {RDW, 2'd3, 2'd0, 6'd0,  1'b1, 1'b0, 6'd0},
    {STP, 2'd2, 2'd3, 6'd0,  1'b1, 1'b0, 6'd0},
    {RDP, 2'd2, 2'd3, 6'd0,  1'b1, 1'b0, 6'd63},
    {WRP, 2'd0, 2'd1, 6'd7,  1'b0, 1'b1, 6'd0},
    {RDP, 2'd0, 2'd1, 6'd0,  1'b0, 1'b0, 6'd9},
    {WRW, 2'd0, 2'd0, 6'd33, 1'b0, 1'b0, 6'd0},
    {RDW, 2'd0, 2'd0, 6'd0,  1'b0, 1'b0, 6'd33},
    {STP, 2'd0, 2'd1, 6'd0,  1'b0, 1'b1, 6'd0},
    {RDP, 2'd0, 2'd1, 6'd0,  1'b1, 1'b0, 6'd9},
    {LDP, 2'd0, 2'd2, 6'd0,  1'b0, 1'b0, 6'd0},
    {RDW, 2'd0, 2'd0, 6'd0,  1'b1, 1'b0, 6'd45},
    {LDP, 2'd3, 2'd0, 6'd0,  1'b1, 1'b0, 6'd0},
    {RDW, 2'd3, 2'd0, 6'd0,  1'b1, 1'b0, 6'd63}
  };

  function automatic string req_of(input logic [2:0] c, input logic w);
    if (!w) return "R8";
    case (c)
      RDW, WRW: return "R3";
      RDP, WRP: return "R4";
      LDP:      return "R5";
      STP:      return "R6";
      default:  return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic do_op(input logic [2:0] c, input logic [1:0] p, input logic [1:0] s,
                       input logic [5:0] d, input logic w,
                       output logic rf, output logic rv, output logic [5:0] rdv);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_pot = p; op_slot = s; op_data = d; wp_n = w;
    @(posedge clk); #1 rf = op_refused;
    @(negedge clk);
    op_valid = 1'b0; wp_n = 1'b1;
    @(posedge clk); #1 rv = rd_valid; rdv = rd_data;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic rf, rv;
    logic [5:0] rdv;
    int cnt;

    // reset state (R2, R1)
    repeat (3) @(posedge clk);
    #1;
    chk("R2 reset taps", tap_sel, {4{64'd1}});
    chk("R2 reset rd_valid", {63'd0, rd_valid}, 64'd0);
    chk("R2 reset busy", {63'd0, busy}, 64'd1);
    @(negedge clk) rst = 1'b0;
    wait_idle();

    // vector table (R3..R8, R1)
    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      logic is_rd;
      v = VEC[i];
      is_rd = (v[20:18] == RDW) || (v[20:18] == RDP);
      wait_idle();
      do_op(v[20:18], v[17:16], v[15:14], v[13:8], v[7], rf, rv, rdv);
      chk(req_of(v[20:18], v[7]), {63'd0, rf}, {63'd0, v[6]});
      chk(req_of(v[20:18], v[7]), {63'd0, rv}, {63'd0, is_rd && !v[6]});
      if (is_rd) chk(req_of(v[20:18], v[7]), {58'd0, rdv}, {58'd0, v[5:0]});
      if (v[20:18] == RDW)
        chk("R1 tap", tap_sel[v[17:16]*64 +: 64], 64'd1 << v[5:0]);
    end

    // busy window length (R9)
    wait_idle();
    @(negedge clk);
    op_valid = 1'b1; op_code = WRP; op_pot = 2'd1; op_slot = 2'd1; op_data = 6'd17;
    @(posedge clk); #1;
    chk("R9 busy low after first edge", {63'd0, busy}, 64'd0);
    @(negedge clk) op_valid = 1'b0;
    cnt = 0;
    repeat (WRC + 10) begin
      @(posedge clk); #1;
      if (busy) cnt++;
    end
    chk("R9 busy length", 64'(cnt), 64'(WRC));
    do_op(RDP, 2'd1, 2'd1, 6'd0, 1'b1, rf, rv, rdv);
    chk("R9 preset written", {58'd0, rdv}, 64'd17);

    // operations during busy (R10)
    do_op(WRP, 2'd0, 2'd3, 6'd11, 1'b1, rf, rv, rdv);
    chk("R10 first write accepted", {63'd0, rf}, 64'd0);
    do_op(WRP, 2'd0, 2'd3, 6'd12, 1'b1, rf, rv, rdv);
    chk("R10 write refused", {63'd0, rf}, 64'd1);
    do_op(RDP, 2'd0, 2'd3, 6'd0, 1'b1, rf, rv, rdv);
    chk("R10 read not refused", {63'd0, rf}, 64'd0);
    chk("R10 read value", {58'd0, rdv}, 64'd11);
    do_op(STP, 2'd1, 2'd3, 6'd0, 1'b1, rf, rv, rdv);
    chk("R10 save refused", {63'd0, rf}, 64'd1);
    do_op(WRW, 2'd1, 2'd0, 6'd40, 1'b1, rf, rv, rdv);
    chk("R10 wiper write accepted", {63'd0, rf}, 64'd0);
    do_op(RDW, 2'd1, 2'd0, 6'd0, 1'b1, rf, rv, rdv);
    chk("R10 wiper value", {58'd0, rdv}, 64'd40);
    chk("R10 busy still high", {63'd0, busy}, 64'd1);
    wait_idle();
    do_op(RDP, 2'd0, 2'd3, 6'd0, 1'b1, rf, rv, rdv);
    chk("R10 preset unchanged", {58'd0, rdv}, 64'd11);

    // recall after reset (R2)
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    do_op(RDW, 2'd0, 2'd0, 6'd0, 1'b1, rf, rv, rdv);
    chk("R2 op during recall refused", {63'd0, rf}, 64'd1);
    chk("R2 no read during recall", {63'd0, rv}, 64'd0);
    wait_idle();
    begin
      logic [5:0] exp_w [4];
      exp_w = '{6'd10, 6'd20, 6'd30, 6'd63};
      for (int p = 0; p < 4; p++) begin
        do_op(RDW, 2'(p), 2'd0, 6'd0, 1'b1, rf, rv, rdv);
        chk("R2 recalled wiper", {58'd0, rdv}, {58'd0, exp_w[p]});
        chk("R1 recalled tap", tap_sel[p*64 +: 64], 64'd1 << exp_w[p]);
        chk("R1 one line", 64'($countones(tap_sel[p*64 +: 64])), 64'd1);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule